// File: doc/BRIEF.md
# Memory Tag Check Unit

This unit guards loads and stores with lock-and-key tags. A small on-chip tag store keeps one 4-bit allocation tag for each 16-byte granule of a 4 KiB modelled range. Each access brings a 64-bit pointer whose bits [59:56] carry the logical tag. The unit looks up the allocation tag of the addressed granule and compares the two. A mismatch either raises a one-cycle fault pulse with the faulting pointer or, in imprecise mode, sets a sticky fail bit for the exception level of the access.

A second port carries tag commands. Each command forms a granule address from a base pointer plus a signed granule offset. It can write the logical tag of a source value into one granule or into two neighbouring granules. It can also read a granule's tag and merge it into a destination value. A configuration write port sets the global check-override bit and the imprecise-mode bit, and clears fail-status bits.

Top module: `mtag_check_unit`

## Requirements
- R1: The granule index of an access is pointer bits [11:4]. Pointer bits [63:12] take no part in the lookup, and bits [63:60] take no part in the compare.
- R2: An access passes when pointer bits [59:56] equal the stored tag. In precise mode, a mismatch drives fault_o high for exactly the cycle that follows the strobe edge, with fault_addr_o equal to the whole pointer.
- R3: When cmd_op_i is 2'b01, the unit writes cmd_src_i[59:56] into granule ((cmd_base_i + sign_extend(cmd_off_i) * 16) >> 4) mod 256. An access in the next cycle sees the new tag.
- R4: When cmd_op_i is 2'b10, the unit writes the same tag into the addressed granule and into the next granule, wrapping from 255 to 0.
- R5: When cmd_op_i is 2'b11, ld_valid_o is high in the next cycle. ld_data_o then equals cmd_src_i with bits [59:56] replaced by the addressed granule's tag, and all other bits are unchanged.
- R6: While the override bit is set, no access raises fault_o and no access changes fail_status_o.
- R7: While imprecise mode is set, a mismatch raises no fault_o. It sets fail_status_o bit acc_el_i on the next edge instead.
- R8: Fail-status bits are sticky. A configuration write clears each bit whose cfg_fsr_i bit is 0 and keeps each bit whose cfg_fsr_i bit is 1. A mismatch that sets a bit wins over a clear in the same cycle.
- R9: After reset, every tag is zero, the override bit, the imprecise-mode bit and all status bits are clear, and fault_o and ld_valid_o are low.
- R10: A command with cmd_op_i 2'b00 changes no tag. An access with acc_valid_i low never faults. An access in the same cycle as a tag write to its granule is checked against the old tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Access strobe |
| acc_ptr_i | input | 64 | Access pointer, logical tag in [59:56] |
| acc_el_i | input | 2 | Exception level of the access |
| cmd_valid_i | input | 1 | Tag command strobe |
| cmd_op_i | input | 2 | 00 none, 01 write tag, 10 write tag pair, 11 read tag |
| cmd_base_i | input | 64 | Command base pointer |
| cmd_off_i | input | 9 | Signed granule offset |
| cmd_src_i | input | 64 | Tag source (writes) or destination value (reads) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_tco_i | input | 1 | New check-override value |
| cfg_async_i | input | 1 | New imprecise-mode value |
| cfg_fsr_i | input | 4 | Fail-status keep mask, 0 clears |
| fault_o | output | 1 | One-cycle tag-mismatch pulse |
| fault_addr_o | output | 64 | Pointer of the faulting access |
| ld_valid_o | output | 1 | Tag-read result valid |
| ld_data_o | output | 64 | Destination value with merged tag |
| fail_status_o | output | 4 | Sticky fail bits, one per exception level |

## Verification
On every cycle the assertions check five things. A fault pulse always traces back to a strobe. The override and imprecise mode suppress faults. Status bits stay set until a zero is written to them. A tag read answers one cycle later and keeps the untouched bits of its destination. Which tag a granule holds can only be shown by the bench's scenarios. These cover negative offsets, pair writes across the top of the range, aliased upper pointer bits, and the read-before-write ordering between a tag write and an access in the same cycle.

// File: rtl/mtag_pkg.sv
package mtag_pkg;
  typedef enum logic [1:0] {
    OP_NONE    = 2'b00,
    OP_TAG_WR  = 2'b01,
    OP_TAG_WR2 = 2'b10,
    OP_TAG_RD  = 2'b11
  } tag_op_e;
endpackage

// File: rtl/mtag_addr_gen.sv
module mtag_addr_gen #(
  parameter int VA_W     = 56,
  parameter int OFF_W    = 9,
  parameter int GRAN_LSB = 4,
  parameter int IDX_W    = 8
) (
  input  logic [VA_W-1:0]  base_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] idx_next_o
);
  logic [VA_W-1:0] off_ext;
  logic [VA_W-1:0] byte_addr;

  always_comb begin
    off_ext    = {{(VA_W-OFF_W){off_i[OFF_W-1]}}, off_i};
    byte_addr  = base_i + (off_ext << GRAN_LSB);
    idx_o      = byte_addr[GRAN_LSB +: IDX_W];
    idx_next_o = idx_o + IDX_W'(1);
  end
endmodule

// File: rtl/mtag_tag_mem.sv
module mtag_tag_mem #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  output logic [TAG_W-1:0] rd_a_tag_o,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  output logic [TAG_W-1:0] rd_b_tag_o,
  input  logic             wr0_en_i,
  input  logic [IDX_W-1:0] wr0_idx_i,
  input  logic             wr1_en_i,
  input  logic [IDX_W-1:0] wr1_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] tags_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_gran
    logic hit;
    assign hit = (wr0_en_i && wr0_idx_i == IDX_W'(g)) ||
                 (wr1_en_i && wr1_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  tags_q[g] <= '0;
      else if (hit) tags_q[g] <= wr_tag_i;
    end
  end

  assign rd_a_tag_o = tags_q[rd_a_idx_i];
  assign rd_b_tag_o = tags_q[rd_b_idx_i];
endmodule

// File: rtl/mtag_fail_status.sv
module mtag_fail_status #(
  parameter int NUM_EL = 4,
  localparam int EL_W  = $clog2(NUM_EL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [EL_W-1:0]   set_el_i,
  input  logic              wr_i,
  input  logic [NUM_EL-1:0] keep_i,
  output logic [NUM_EL-1:0] status_o
);
  for (genvar e = 0; e < NUM_EL; e++) begin : g_el
    logic bit_q;
    logic set_hit;
    assign set_hit = set_i && (set_el_i == EL_W'(e));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   bit_q <= 1'b0;
      else if (set_hit)              bit_q <= 1'b1;
      else if (wr_i && !keep_i[e])   bit_q <= 1'b0;
    end
    assign status_o[e] = bit_q;
  end
endmodule

// File: rtl/mtag_check_unit.sv
module mtag_check_unit #(
  parameter int PTR_W    = 64,
  parameter int VA_W     = 56,
  parameter int TAG_W    = 4,
  parameter int TAG_LSB  = 56,
  parameter int GRAN_LSB = 4,
  parameter int IDX_W    = 8,
  parameter int OFF_W    = 9,
  parameter int NUM_EL   = 4,
  localparam int EL_W    = $clog2(NUM_EL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [PTR_W-1:0]  acc_ptr_i,
  input  logic [EL_W-1:0]   acc_el_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [PTR_W-1:0]  cmd_base_i,
  input  logic [OFF_W-1:0]  cmd_off_i,
  input  logic [PTR_W-1:0]  cmd_src_i,
  input  logic              cfg_we_i,
  input  logic              cfg_tco_i,
  input  logic              cfg_async_i,
  input  logic [NUM_EL-1:0] cfg_fsr_i,
  output logic              fault_o,
  output logic [PTR_W-1:0]  fault_addr_o,
  output logic              ld_valid_o,
  output logic [PTR_W-1:0]  ld_data_o,
  output logic [NUM_EL-1:0] fail_status_o
);
  import mtag_pkg::*;

  logic             tco_q, async_q;
  logic [IDX_W-1:0] acc_idx, cmd_idx, cmd_idx_nx;
  logic [TAG_W-1:0] acc_mem_tag, cmd_mem_tag, acc_log_tag;
  logic             mismatch, fault_d, imprecise_set;
  logic             wr0_en, wr1_en, rd_en;
  tag_op_e          op;

  assign op          = tag_op_e'(cmd_op_i);
  assign acc_idx     = acc_ptr_i[GRAN_LSB +: IDX_W];
  assign acc_log_tag = acc_ptr_i[TAG_LSB +: TAG_W];

  mtag_addr_gen #(
    .VA_W(VA_W), .OFF_W(OFF_W), .GRAN_LSB(GRAN_LSB), .IDX_W(IDX_W)
  ) u_addr (
    .base_i     (cmd_base_i[VA_W-1:0]),
    .off_i      (cmd_off_i),
    .idx_o      (cmd_idx),
    .idx_next_o (cmd_idx_nx)
  );

  assign wr0_en = cmd_valid_i && (op == OP_TAG_WR || op == OP_TAG_WR2);
  assign wr1_en = cmd_valid_i && (op == OP_TAG_WR2);
  assign rd_en  = cmd_valid_i && (op == OP_TAG_RD);

  mtag_tag_mem #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_mem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_a_idx_i (acc_idx),
    .rd_a_tag_o (acc_mem_tag),
    .rd_b_idx_i (cmd_idx),
    .rd_b_tag_o (cmd_mem_tag),
    .wr0_en_i   (wr0_en),
    .wr0_idx_i  (cmd_idx),
    .wr1_en_i   (wr1_en),
    .wr1_idx_i  (cmd_idx_nx),
    .wr_tag_i   (cmd_src_i[TAG_LSB +: TAG_W])
  );

  // checks gated by the override as it stood before any same-cycle write
  assign mismatch      = acc_valid_i && !tco_q && (acc_log_tag != acc_mem_tag);
  assign fault_d       = mismatch && !async_q;
  assign imprecise_set = mismatch && async_q;

  mtag_fail_status #(.NUM_EL(NUM_EL)) u_fsr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (imprecise_set),
    .set_el_i (acc_el_i),
    .wr_i     (cfg_we_i),
    .keep_i   (cfg_fsr_i),
    .status_o (fail_status_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tco_q   <= 1'b0;
      async_q <= 1'b0;
    end else if (cfg_we_i) begin
      tco_q   <= cfg_tco_i;
      async_q <= cfg_async_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o      <= 1'b0;
      fault_addr_o <= '0;
    end else begin
      fault_o <= fault_d;
      if (fault_d) fault_addr_o <= acc_ptr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_valid_o <= 1'b0;
      ld_data_o  <= '0;
    end else begin
      ld_valid_o <= rd_en;
      if (rd_en) begin
        ld_data_o                       <= cmd_src_i;
        ld_data_o[TAG_LSB +: TAG_W]     <= cmd_mem_tag;
      end
    end
  end
endmodule

// File: rtl/mtag_check_sva.sv
module mtag_check_sva #(
  parameter int PTR_W   = 64,
  parameter int TAG_W   = 4,
  parameter int TAG_LSB = 56,
  parameter int NUM_EL  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_valid_i,
  input logic              cmd_valid_i,
  input logic [1:0]        cmd_op_i,
  input logic [PTR_W-1:0]  cmd_src_i,
  input logic              cfg_we_i,
  input logic [NUM_EL-1:0] cfg_fsr_i,
  input logic              tco_q,
  input logic              async_q,
  input logic              fault_o,
  input logic              ld_valid_o,
  input logic [PTR_W-1:0]  ld_data_o,
  input logic [NUM_EL-1:0] fail_status_o
);
  // R2: a fault pulse needs a strobe one edge earlier
  a_r2_fault_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i == 1'b0 |=> !fault_o);

  // R6: override suppresses faults
  a_r6_override_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && tco_q) |=> !fault_o);

  // R7: imprecise mode never pulses
  a_r7_imprecise_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && async_q) |=> !fault_o);

  // R5: read answers one cycle later and keeps non-tag bits
  a_r5_read_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'b11) |=> ld_valid_o);

  a_r5_read_keeps_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'b11) |=>
      (ld_data_o[TAG_LSB-1:0] == $past(cmd_src_i[TAG_LSB-1:0]) &&
       ld_data_o[PTR_W-1:TAG_LSB+TAG_W] == $past(cmd_src_i[PTR_W-1:TAG_LSB+TAG_W])));

  // R8: sticky bits fall only through a zero write
  for (genvar e = 0; e < NUM_EL; e++) begin : g_sticky
    a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fail_status_o[e] && !(cfg_we_i && !cfg_fsr_i[e])) |=> fail_status_o[e]);
  end
endmodule

bind mtag_check_unit mtag_check_sva #(
  .PTR_W(PTR_W), .TAG_W(TAG_W), .TAG_LSB(TAG_LSB), .NUM_EL(NUM_EL)
) u_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .acc_valid_i   (acc_valid_i),
  .cmd_valid_i   (cmd_valid_i),
  .cmd_op_i      (cmd_op_i),
  .cmd_src_i     (cmd_src_i),
  .cfg_we_i      (cfg_we_i),
  .cfg_fsr_i     (cfg_fsr_i),
  .tco_q         (tco_q),
  .async_q       (async_q),
  .fault_o       (fault_o),
  .ld_valid_o    (ld_valid_o),
  .ld_data_o     (ld_data_o),
  .fail_status_o (fail_status_o)
);

// File: tb/mtag_check_unit_tb.sv
`timescale 1ns/1ps
module mtag_check_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_valid_i = 1'b0;
  logic [63:0] acc_ptr_i = '0;
  logic [1:0]  acc_el_i = '0;
  logic        cmd_valid_i = 1'b0;
  logic [1:0]  cmd_op_i = '0;
  logic [63:0] cmd_base_i = '0;
  logic [8:0]  cmd_off_i = '0;
  logic [63:0] cmd_src_i = '0;
  logic        cfg_we_i = 1'b0;
  logic        cfg_tco_i = 1'b0;
  logic        cfg_async_i = 1'b0;
  logic [3:0]  cfg_fsr_i = '0;
  logic        fault_o;
  logic [63:0] fault_addr_o;
  logic        ld_valid_o;
  logic [63:0] ld_data_o;
  logic [3:0]  fail_status_o;

  always #10 clk_i = ~clk_i;

  mtag_check_unit u_dut (.*);

  typedef struct {
    logic        fault;
    logic [63:0] addr;
    logic        ldv;
    logic [63:0] ldd;
    logic [3:0]  fsr;
    string       req;
  } exp_t;

  exp_t exp_q [$];
  int   checks = 0;
  int   fails = 0;

  logic [3:0] m_tag [256];
  logic       m_tco = 1'b0, m_async = 1'b0;
  logic [3:0] m_fsr = '0;

  function automatic logic [7:0] gidx(input logic [63:0] base, input logic [8:0] off);
    logic [55:0] a;
    a = base[55:0] + ({{47{off[8]}}, off} << 4);
    return a[11:4];
  endfunction

  task automatic tick(input string req);
    exp_t e;
    logic mism;
    logic [7:0] g;
    e.req   = req;
    mism    = acc_valid_i && !m_tco && (acc_ptr_i[59:56] != m_tag[acc_ptr_i[11:4]]);
    e.fault = mism && !m_async;
    e.addr  = acc_ptr_i;
    g       = gidx(cmd_base_i, cmd_off_i);
    e.ldv   = cmd_valid_i && cmd_op_i == 2'b11;
    e.ldd   = cmd_src_i;
    e.ldd[59:56] = m_tag[g];
    if (cfg_we_i) m_fsr = m_fsr & cfg_fsr_i;
    if (mism && m_async) m_fsr[acc_el_i] = 1'b1;
    e.fsr = m_fsr;
    if (cfg_we_i) begin m_tco = cfg_tco_i; m_async = cfg_async_i; end
    if (cmd_valid_i && (cmd_op_i == 2'b01 || cmd_op_i == 2'b10)) m_tag[g] = cmd_src_i[59:56];
    if (cmd_valid_i && cmd_op_i == 2'b10) m_tag[g + 8'd1] = cmd_src_i[59:56];
    @(posedge clk_i);
    exp_q.push_back(e);
    @(negedge clk_i);
    acc_valid_i = 1'b0; cmd_valid_i = 1'b0; cfg_we_i = 1'b0;
  endtask

  task automatic acc(input logic [63:0] p, input logic [1:0] el);
    acc_valid_i = 1'b1; acc_ptr_i = p; acc_el_i = el;
  endtask

  task automatic cmd(input logic [1:0] op, input logic [63:0] b,
                     input logic [8:0] o, input logic [63:0] s);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_base_i = b; cmd_off_i = o; cmd_src_i = s;
  endtask

  task automatic cfg(input logic t, input logic a, input logic [3:0] k);
    cfg_we_i = 1'b1; cfg_tco_i = t; cfg_async_i = a; cfg_fsr_i = k;
  endtask

  // monitor
  initial forever begin
    @(negedge clk_i);
    if (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (fault_o !== e.fault || (e.fault && fault_addr_o !== e.addr) ||
          ld_valid_o !== e.ldv || (e.ldv && ld_data_o !== e.ldd) ||
          fail_status_o !== e.fsr) begin
        fails++;
        $display("FAIL %s: act fault=%b addr=%h ldv=%b ldd=%h fsr=%b exp fault=%b addr=%h ldv=%b ldd=%h fsr=%b",
                 e.req, fault_o, fault_addr_o, ld_valid_o, ld_data_o, fail_status_o,
                 e.fault, e.addr, e.ldv, e.ldd, e.fsr);
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: act hung exp done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) m_tag[i] = '0;
    repeat (3) @(negedge clk_i);
    // R9: reset state
    checks++;
    if (fault_o !== 1'b0 || ld_valid_o !== 1'b0 || fail_status_o !== 4'b0) begin
      fails++;
      $display("FAIL R9: act fault=%b ldv=%b fsr=%b exp 0 0 0000", fault_o, ld_valid_o, fail_status_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    tick("R9 idle");
    acc(64'h0000_0000_0000_0ab0, 2'd0); tick("R9 tag zero pass");
    cmd(2'b11, 64'h80, 9'd0, 64'hffff_ffff_ffff_ffff); tick("R9 read zero tag");
    // R2 mismatch precise
    acc(64'h0500_0000_0000_0034, 2'd1); tick("R2 mismatch fault");
    tick("R2 single pulse");
    // R3 tag write then pass
    cmd(2'b01, 64'h30, 9'd0, 64'h0500_0000_0000_0000); tick("R3 write");
    acc(64'h0500_0000_0000_0038, 2'd1); tick("R3 match pass");
    acc(64'h0600_0000_0000_0038, 2'd1); tick("R2 wrong tag");
    // R1 upper bits ignored
    acc(64'hf5ab_cdef_0123_4030, 2'd0); tick("R1 aliased pass");
    acc(64'h15ff_ffff_ffff_f03c, 2'd0); tick("R1 top nibble ignored");
    // R3/R5 negative offset
    cmd(2'b01, 64'h100, 9'h1fe, 64'h0a00_0000_0000_0000); tick("R3 neg offset write");
    cmd(2'b11, 64'h0e0, 9'd0, 64'h1234_5678_9abc_def0); tick("R5 read merge");
    cmd(2'b11, 64'h0f0, 9'h1ff, 64'hfedc_ba98_7654_3210); tick("R5 read neg offset");
    // R4 pair
    cmd(2'b10, 64'h200, 9'd1, 64'h0700_0000_0000_0000); tick("R4 pair write");
    acc(64'h0700_0000_0000_0210, 2'd0); tick("R4 first granule");
    acc(64'h0700_0000_0000_0220, 2'd0); tick("R4 second granule");
    acc(64'h0700_0000_0000_0230, 2'd0); tick("R4 third untouched");
    cmd(2'b10, 64'hff0, 9'd0, 64'h0c00_0000_0000_0000); tick("R4 pair wrap");
    cmd(2'b11, 64'h000, 9'd0, 64'h0); tick("R4 wrap read low");
    cmd(2'b11, 64'hff0, 9'd0, 64'h0); tick("R4 wrap read high");
    // R10
    cmd(2'b00, 64'h300, 9'd0, 64'h0f00_0000_0000_0000); tick("R10 no-op cmd");
    cmd(2'b11, 64'h300, 9'd0, 64'h0); tick("R10 no-op left tag");
    acc_ptr_i = 64'h0900_0000_0000_0030; tick("R10 no strobe no fault");
    acc(64'h0500_0000_0000_0400, 2'd0);
    cmd(2'b01, 64'h400, 9'd0, 64'h0500_0000_0000_0000); tick("R10 same-cycle old tag");
    acc(64'h0500_0000_0000_0400, 2'd0); tick("R10 new tag next cycle");
    // R6 override
    cfg(1'b1, 1'b0, 4'hf); tick("R6 set override");
    acc(64'h0e00_0000_0000_0030, 2'd3); tick("R6 no fault");
    cfg(1'b1, 1'b1, 4'hf); tick("R6 override and imprecise");
    acc(64'h0e00_0000_0000_0030, 2'd3); tick("R6 no status");
    // R7 imprecise
    cfg(1'b0, 1'b1, 4'hf); tick("R7 imprecise only");
    acc(64'h0e00_0000_0000_0030, 2'd2); tick("R7 sets el2");
    acc(64'h0e00_0000_0000_0030, 2'd0); tick("R7 sets el0");
    acc(64'h0500_0000_0000_0030, 2'd1); tick("R7 match no set");
    // R8 sticky
    tick("R8 holds");
    cfg(1'b0, 1'b1, 4'b1111); tick("R8 ones keep");
    cfg(1'b0, 1'b1, 4'b1110); tick("R8 zero clears bit0");
    acc(64'h0e00_0000_0000_0030, 2'd2);
    cfg(1'b0, 1'b1, 4'b1011); tick("R8 set beats clear");
    cfg(1'b0, 1'b0, 4'b0000); tick("R8 clear all");
    acc(64'h0e00_0000_0000_0030, 2'd1); tick("R2 precise again");
    repeat (3) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule